// File: doc/BRIEF.md
# Condition Register File with Same-Cycle Forwarding

This block holds a 32-bit condition register as one storage word made of eight 4-bit fields. A write carries a full data word and an 8-bit field-enable mask, so only the enabled fields change. Several pipeline units can request a write. The design permits at most one of them per cycle, and it checks that rule.

The read port always returns the whole 32-bit word. A write in flight in the current cycle already shows on that port. Each enabled field comes from the incoming data, and every other field comes from the stored word. The same merged word is loaded into storage at the next rising clock edge. A consumer therefore sees a producer's result without waiting a cycle.

Top module: `cond_reg_file`

## Requirements
- R1: While `rst_n` is low, the stored word is zero. After reset, with no write requested, `rd_data` reads 0x00000000.
- R2: In a cycle where a write is requested, `rd_data` returns the merged word in that same cycle. Field k (bits 4k+3..4k) comes from the write data when mask bit k is set, and from the stored word otherwise.
- R3: At the rising clock edge, the fields enabled by the write mask take the write data. All other fields keep their stored value, so a later idle cycle reads the merged word.
- R4: A cycle with no write request, or with a request whose mask is all zeros, changes neither `rd_data` nor the stored word.
- R5: Source s supplies its data from `wr_data[32*s+31 : 32*s]` and its mask from `wr_mask[8*s+7 : 8*s]`. Whichever source raises its bit of `wr_valid` is the one written. The data and masks of sources that are not requesting are ignored.
- R6: At most one bit of `wr_valid` may be high in any cycle, and an assertion flags a violation.
- R7: A write with mask 0xFF replaces the full 32-bit word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| wr_valid | input | NUM_SRC | One write request bit per source; at most one may be set |
| wr_data | input | 32*NUM_SRC | Write data for each source, packed by source index |
| wr_mask | input | 8*NUM_SRC | Field-enable mask for each source, packed by source index |
| rd_data | output | 32 | Stored word merged with any write in the current cycle |

## Verification
The forwarded value is combinational, so each write's effect on `rd_data` is due in the same cycle. The stored effect is due one edge later, and shows on `rd_data` in the first cycle after that edge. The bench drives inputs just after the falling edge and compares `rd_data` with a merge computed from its own model a moment later, before the rising edge. It then advances its model at the rising edge, so the next cycle's check covers the stored result. The reset check is made while `rst_n` is held low, with all write requests idle.

// File: rtl/cond_reg_pkg.sv
package cond_reg_pkg;
  localparam int unsigned FIELD_W  = 4;
  localparam int unsigned N_FIELDS = 8;
  localparam int unsigned WORD_W   = FIELD_W * N_FIELDS;

  typedef logic [WORD_W-1:0]   cr_word_t;
  typedef logic [N_FIELDS-1:0] cr_mask_t;

  typedef struct packed {
    logic     valid;
    cr_mask_t mask;
    cr_word_t data;
  } cr_write_t;
endpackage

// File: rtl/cr_write_select.sv
module cr_write_select
  import cond_reg_pkg::*;
#(
  parameter int unsigned NUM_SRC = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_SRC-1:0]         src_valid,
  input  logic [WORD_W*NUM_SRC-1:0]  src_data,
  input  logic [N_FIELDS*NUM_SRC-1:0] src_mask,
  output cr_write_t                  sel_wr
);
  always_comb begin
    sel_wr = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (src_valid[s]) begin
        sel_wr.valid = 1'b1;
        sel_wr.data  = sel_wr.data | src_data[WORD_W*s +: WORD_W];
        sel_wr.mask  = sel_wr.mask | src_mask[N_FIELDS*s +: N_FIELDS];
      end
    end
  end

  // R6: the port accepts a single writer per cycle
  assert_single_writer_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(src_valid));
endmodule

// File: rtl/cr_field_merge.sv
module cr_field_merge
  import cond_reg_pkg::*;
(
  input  cr_word_t  old_word,
  input  cr_write_t wr,
  output cr_word_t  merged,
  output logic      changes
);
  for (genvar f = 0; f < N_FIELDS; f++) begin : g_field
    always_comb begin
      if (wr.valid && wr.mask[f])
        merged[FIELD_W*f +: FIELD_W] = wr.data[FIELD_W*f +: FIELD_W];
      else
        merged[FIELD_W*f +: FIELD_W] = old_word[FIELD_W*f +: FIELD_W];
    end
  end

  assign changes = wr.valid && (|wr.mask);
endmodule

// File: rtl/cr_store.sv
module cr_store
  import cond_reg_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load_en,
  input  cr_word_t load_word,
  output cr_word_t stored
);
  cr_word_t q_r;
  cr_word_t q_nxt;

  always_comb begin
    q_nxt = q_r;
    if (load_en) q_nxt = load_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q_r <= '0;
    else if (load_en) q_r <= q_nxt;
  end

  assign stored = q_r;

  // R4: no load leaves the word untouched
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(q_r));
  // R3: a load is visible in storage after the edge
  assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (q_r == $past(load_word)));
endmodule

// File: rtl/cond_reg_file.sv
module cond_reg_file
  import cond_reg_pkg::*;
#(
  parameter int unsigned NUM_SRC = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_SRC-1:0]          wr_valid,
  input  logic [WORD_W*NUM_SRC-1:0]   wr_data,
  input  logic [N_FIELDS*NUM_SRC-1:0] wr_mask,
  output logic [WORD_W-1:0]           rd_data
);
  cr_write_t sel_wr;
  cr_word_t  stored;
  cr_word_t  merged;
  logic      load_en;

  cr_write_select #(.NUM_SRC(NUM_SRC)) u_sel (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_valid (wr_valid),
    .src_data  (wr_data),
    .src_mask  (wr_mask),
    .sel_wr    (sel_wr)
  );

  cr_field_merge u_merge (
    .old_word (stored),
    .wr       (sel_wr),
    .merged   (merged),
    .changes  (load_en)
  );

  cr_store u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (load_en),
    .load_word (merged),
    .stored    (stored)
  );

  assign rd_data = merged;

  // R2/R4: without a request the read port shows the stored word
  assert_idle_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid == '0) |-> (rd_data == stored));
  // R7: a full-mask write makes the read port equal the stored word next cycle
  assert_full_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_wr.valid && (&sel_wr.mask)) |=> (stored == $past(sel_wr.data)));
endmodule

// File: tb/cond_reg_file_test.sv
module cond_reg_file_test;
  localparam int NSRC = 3;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [NSRC-1:0]  wr_valid;
  logic [32*NSRC-1:0] wr_data;
  logic [8*NSRC-1:0]  wr_mask;
  logic [31:0]      rd_data;

  int errors = 0;
  int checks = 0;
  logic [31:0] model;

  cond_reg_file #(.NUM_SRC(NSRC)) uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid),
    .wr_data(wr_data), .wr_mask(wr_mask), .rd_data(rd_data)
  );

  always #5 clk = ~clk;

  function automatic logic [31:0] merge_fn(logic [31:0] old, logic [31:0] d, logic [7:0] m);
    logic [31:0] r = old;
    for (int f = 0; f < 8; f++) if (m[f]) r[4*f +: 4] = d[4*f +: 4];
    return r;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: rd_data=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle: src<0 means no writer; noise fills all other sources
  task automatic cycle(int src, logic [31:0] d, logic [7:0] m, string req);
    logic [31:0] exp;
    @(negedge clk);
    wr_valid = '0;
    for (int s = 0; s < NSRC; s++) begin
      wr_data[32*s +: 32] = $urandom;
      wr_mask[8*s +: 8]   = $urandom;
    end
    exp = model;
    if (src >= 0) begin
      wr_valid[src] = 1'b1;
      wr_data[32*src +: 32] = d;
      wr_mask[8*src +: 8]   = m;
      exp = merge_fn(model, d, m);
    end
    #1;
    check(req, rd_data, exp);
    @(posedge clk);
    model = exp;
  endtask

  initial begin
    void'($urandom(32'h5eed_c0de));
    rst_n = 1'b0; wr_valid = '0; wr_data = '0; wr_mask = '0; model = '0;
    repeat (3) @(posedge clk);
    #2 check("R1 reset", rd_data, 32'h0);
    @(negedge clk) rst_n = 1'b1;

    cycle(-1, 0, 0, "R1 idle after reset");
    cycle(0, 32'hDEAD_BEEF, 8'hFF, "R7 full write forward");
    cycle(-1, 0, 0, "R7 full write stored");
    cycle(1, 32'h1234_5678, 8'h00, "R4 zero mask forward");
    cycle(-1, 0, 0, "R4 zero mask stored");
    cycle(2, 32'h0000_000A, 8'h01, "R2 low field forward");
    cycle(-1, 0, 0, "R3 low field stored");
    cycle(1, 32'h7000_0000, 8'h80, "R5 source 1 top field");
    cycle(-1, 0, 0, "R3 top field stored");
    cycle(0, 32'hAAAA_5555, 8'h5A, "R2 alternating fields");
    cycle(-1, 0, 0, "R4 no request");
    for (int f = 0; f < 8; f++)
      cycle(f % NSRC, 32'hFFFF_FFFF, 8'(1 << f), "R3 walking field");
    cycle(-1, 0, 0, "R3 all fields walked");

    for (int i = 0; i < 400; i++) begin
      int sel = int'($urandom_range(NSRC, 0)) - 1;
      logic [7:0] m = $urandom;
      if (i % 17 == 0) m = 8'h00;
      if (i % 23 == 0) m = 8'hFF;
      cycle(sel, $urandom, m, "R2 R5 random");
    end

    @(negedge clk) rst_n = 1'b0; wr_valid = '0;
    #1 check("R1 mid-run reset", rd_data, 32'h0);
    model = '0;
    @(negedge clk) rst_n = 1'b1;
    cycle(-1, 0, 0, "R1 idle after second reset");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: rd_data=%h expected=completion", rd_data);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule